// File: doc/BRIEF.md
# Auto-Reloading Decrementer

This block is a down counter that advances on the time-base tick. Each tick that arrives while the count is above zero lowers it by one. The tick that takes the count from one to zero is an expiry. An expiry sets a sticky status flag. If auto-reload is on, the same expiry also loads the count from a separate reload register, so the counter runs periodically without help from software.

Software writes the counter and the reload register through dedicated write ports. Auto-reload and the interrupt enable are read from a control word that is held outside the block. The interrupt output is a level. It stays high while the status flag and the enable are both set, and software lowers it by writing one to the flag's position in a status write.

Top module: `dec_timer`

## Requirements
- R1: After a synchronous reset the count is zero, the reload register is zero, the status flag is clear and the interrupt is low.
- R2: On each cycle with `tick_i` high, no counter write and a count above one, the count drops by exactly one. Without a tick, the count holds.
- R3: A tick that moves the count from 1 to 0 sets the status flag in the following cycle.
- R4: A count that is already zero stays zero under ticks and never sets the status flag.
- R5: When control bit 22 (auto-reload) is one at expiry, the count takes the value held in the reload register. This includes reload values 0 and 1.
- R6: When control bit 22 is zero at expiry, the count stays at zero afterwards until software writes it.
- R7: Writing the reload register leaves the current count unchanged.
- R8: A counter write takes priority over a decrement or reload in the same cycle, and that cycle raises no expiry.
- R9: A status write whose bit 27 is one clears the flag. A status write whose bit 27 is zero leaves the flag unchanged, whatever its other bits hold.
- R10: `irq_o` is high exactly when the status flag is set and control bit 26 (interrupt enable) is one.
- R11: If an expiry and a clearing status write fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Time-base tick, one decrement per high cycle |
| ctrl_i | input | 32 | External control word; bit 22 enables auto-reload, bit 26 enables the interrupt |
| cnt_we_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | CNT_W | Counter write value |
| rld_we_i | input | 1 | Reload register write strobe |
| rld_wdata_i | input | CNT_W | Reload register write value |
| sts_we_i | input | 1 | Status write strobe |
| sts_wdata_i | input | 32 | Status write value; a one in bit 27 clears the flag |
| count_o | output | CNT_W | Current count |
| flag_o | output | 1 | Sticky expiry status flag |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest cases to reach are collisions, where an expiry lands in the same cycle as another event. One is a counter write on the exact tick that would take the count from one to zero. The other is a clearing status write in that same cycle. Both need the tick and the write to line up on a known cycle. The bench therefore loads the counter to one and applies the colliding write together with the next tick. It also sweeps starting counts and reload values, including reload values 0 and 1, with irregular tick gaps. A per-cycle arithmetic model is checked against every output after each edge.

// File: rtl/dec_pkg.sv
package dec_pkg;

    localparam int unsigned CTL_W        = 32;
    localparam int unsigned CTL_AR_BIT   = 22;
    localparam int unsigned CTL_IE_BIT   = 26;
    localparam int unsigned STS_EXP_BIT  = 27;

    typedef struct packed {
        logic irq_en;
        logic auto_reload;
    } dec_ctl_t;

    typedef enum logic [2:0] {
        SRC_HOLD   = 3'd0,
        SRC_SW     = 3'd1,
        SRC_DEC    = 3'd2,
        SRC_RELOAD = 3'd3,
        SRC_ZERO   = 3'd4
    } cnt_src_e;

    function automatic dec_ctl_t decode_ctl(input logic [CTL_W-1:0] word);
        dec_ctl_t c;
        c.irq_en      = word[CTL_IE_BIT];
        c.auto_reload = word[CTL_AR_BIT];
        return c;
    endfunction

    function automatic logic is_expiry(input cnt_src_e s);
        return (s == SRC_RELOAD) || (s == SRC_ZERO);
    endfunction

endpackage

// File: rtl/dec_counter.sv
module dec_counter
    import dec_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             auto_reload,
    input  logic             sw_we,
    input  logic [CNT_W-1:0] sw_val,
    input  logic             rld_we,
    input  logic [CNT_W-1:0] rld_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] reload_q;
    cnt_src_e         src;

    always_comb begin
        src = SRC_HOLD;
        if (sw_we)
            src = SRC_SW;
        else if (tick && count == ONE)
            src = auto_reload ? SRC_RELOAD : SRC_ZERO;
        else if (tick && count != ZERO)
            src = SRC_DEC;
    end

    assign expire = is_expiry(src);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= ZERO;
        end else begin
            case (src)
                SRC_SW:     count <= sw_val;
                SRC_DEC:    count <= count - ONE;
                SRC_RELOAD: count <= reload_q;
                SRC_ZERO:   count <= ZERO;
                default:    count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            reload_q <= ZERO;
        else if (rld_we)
            reload_q <= rld_val;
    end

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !sw_we) |=> $stable(count)); // R2

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (rst)
        (tick && !sw_we && count > ONE) |=> (count == $past(count) - ONE)); // R2

    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
        (count == ZERO && !sw_we) |=> (count == ZERO)); // R4

    AST_SW_WINS: assert property (@(posedge clk) disable iff (rst)
        sw_we |=> (count == $past(sw_val))); // R8

    AST_RELOAD_LOAD: assert property (@(posedge clk) disable iff (rst)
        (tick && !sw_we && count == ONE && auto_reload && !rld_we)
            |=> (count == reload_q)); // R5

endmodule

// File: rtl/dec_status.sv
module dec_status
    import dec_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             expire,
    input  logic             clr_we,
    input  logic [CTL_W-1:0] clr_data,
    input  logic             irq_en,
    output logic             flag,
    output logic             irq
);
    logic clr_hit;

    assign clr_hit = clr_we && clr_data[STS_EXP_BIT];

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (expire)
            flag <= 1'b1;
        else if (clr_hit)
            flag <= 1'b0;
    end

    assign irq = flag & irq_en;

    AST_SET_ON_EXPIRE: assert property (@(posedge clk) disable iff (rst)
        expire |=> flag); // R3

    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_hit) |=> flag); // R9

    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_hit && !expire) |=> !flag); // R9

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
        (!flag && !expire) |=> !flag); // R4

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq); // R10

endmodule

// File: rtl/dec_timer.sv
module dec_timer
    import dec_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [31:0]      ctrl_i,
    input  logic             cnt_we_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             rld_we_i,
    input  logic [CNT_W-1:0] rld_wdata_i,
    input  logic             sts_we_i,
    input  logic [31:0]      sts_wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             irq_o
);
    dec_ctl_t ctl;
    logic     expire;

    assign ctl = decode_ctl(ctrl_i);

    dec_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick_i),
        .auto_reload (ctl.auto_reload),
        .sw_we       (cnt_we_i),
        .sw_val      (cnt_wdata_i),
        .rld_we      (rld_we_i),
        .rld_val     (rld_wdata_i),
        .count       (count_o),
        .expire      (expire)
    );

    dec_status u_sts (
        .clk      (clk),
        .rst      (rst),
        .expire   (expire),
        .clr_we   (sts_we_i),
        .clr_data (sts_wdata_i),
        .irq_en   (ctl.irq_en),
        .flag     (flag_o),
        .irq      (irq_o)
    );

    AST_SIM_EXPIRE_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (expire && sts_we_i) |=> flag_o); // R11

endmodule

// File: tb/dec_timer_test.sv
module dec_timer_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick_i = 1'b0;
    logic [31:0]  ctrl_i = '0;
    logic         cnt_we_i = 1'b0;
    logic [W-1:0] cnt_wdata_i = '0;
    logic         rld_we_i = 1'b0;
    logic [W-1:0] rld_wdata_i = '0;
    logic         sts_we_i = 1'b0;
    logic [31:0]  sts_wdata_i = '0;
    logic [W-1:0] count_o;
    logic         flag_o;
    logic         irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] mc, mr;
    logic         mf;

    always #2 clk = ~clk;

    dec_timer #(.CNT_W(W)) uut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .ctrl_i(ctrl_i),
        .cnt_we_i(cnt_we_i), .cnt_wdata_i(cnt_wdata_i),
        .rld_we_i(rld_we_i), .rld_wdata_i(rld_wdata_i),
        .sts_we_i(sts_we_i), .sts_wdata_i(sts_wdata_i),
        .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic tk,
                        input logic cwe, input logic [W-1:0] cval,
                        input logic rwe, input logic [W-1:0] rval,
                        input logic swe, input logic [31:0] sdat);
        logic [W-1:0] nc, nr;
        logic nf, ex;
        ex = 1'b0;
        nc = mc;
        if (cwe) nc = cval;
        else if (tk && mc != 0) begin
            if (mc == 1) begin
                ex = 1'b1;
                nc = ctrl_i[22] ? mr : '0;
            end else nc = mc - 1;
        end
        nr = rwe ? rval : mr;
        nf = ex ? 1'b1 : ((swe && sdat[27]) ? 1'b0 : mf);
        tick_i = tk; cnt_we_i = cwe; cnt_wdata_i = cval;
        rld_we_i = rwe; rld_wdata_i = rval;
        sts_we_i = swe; sts_wdata_i = sdat;
        @(posedge clk); #1;
        mc = nc; mr = nr; mf = nf;
        tick_i = 0; cnt_we_i = 0; rld_we_i = 0; sts_we_i = 0;
        check(tag, count_o, mc, "count");
        check(tag, flag_o, mf, "flag");
        check(tag, irq_o, mf & ctrl_i[26], "irq");
    endtask

    task automatic idle(input string tag, input logic tk);
        step(tag, tk, 0, '0, 0, '0, 0, '0);
    endtask

    task automatic clear_flag(input string tag);
        step(tag, 0, 0, '0, 0, '0, 1, 32'h0800_0000);
    endtask

    initial begin
        mc = '0; mr = '0; mf = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R1", count_o, 0, "count");
        check("R1", flag_o, 0, "flag");
        check("R1", irq_o, 0, "irq");
        // R1 reload register reset: auto-reload from zero yields zero
        ctrl_i[22] = 1'b1;
        step("R1", 0, 1, 8'd1, 0, '0, 0, '0);
        idle("R1", 1);
        check("R1", count_o, 0, "reload-after-reset");
        clear_flag("R9");
        ctrl_i[22] = 1'b0;

        // R2/R3 sweep of start values with irregular tick gaps
        for (int s = 1; s <= 14; s++) begin
            step("R2", 0, 1, s[W-1:0], 0, '0, 0, '0);
            for (int k = 0; k < s + s / 2 + 3; k++)
                idle((mc == 1) ? "R3" : "R2", (k % 3) != 2);
            clear_flag("R9");
        end

        // R4/R6: at zero, ticks do nothing
        for (int k = 0; k < 6; k++) idle("R4", 1);
        step("R6", 0, 1, 8'd2, 0, '0, 0, '0);
        for (int k = 0; k < 6; k++) idle("R6", 1);
        clear_flag("R9");

        // R5: auto-reload sweep, including 0 and 1
        ctrl_i[22] = 1'b1;
        for (int r = 0; r < 7; r++) begin
            step("R5", 0, 0, '0, 1, r[W-1:0], 0, '0);
            step("R5", 0, 1, 8'd3, 0, '0, 0, '0);
            for (int k = 0; k < 3 * (r + 2); k++) idle("R5", 1);
            clear_flag("R9");
        end

        // R7: reload writes leave count alone, also while ticking
        step("R7", 0, 1, 8'd50, 0, '0, 0, '0);
        step("R7", 0, 0, '0, 1, 8'h40, 0, '0);
        step("R7", 1, 0, '0, 1, 8'h11, 0, '0);
        check("R7", count_o, 8'd49, "count");

        // R8: counter write collides with expiring tick
        step("R8", 0, 1, 8'd1, 0, '0, 0, '0);
        step("R8", 1, 1, 8'd9, 0, '0, 0, '0);
        check("R8", flag_o, 0, "no expiry");
        ctrl_i[22] = 1'b0;
        step("R8", 0, 1, 8'd1, 0, '0, 0, '0);
        step("R8", 1, 1, 8'd4, 0, '0, 0, '0);
        step("R8", 1, 1, 8'd7, 0, '0, 0, '0);

        // R9/R10: clearing rules and interrupt gating
        step("R3", 0, 1, 8'd1, 0, '0, 0, '0);
        idle("R3", 1);
        for (int e = 0; e < 2; e++) begin
            ctrl_i[26] = e[0];
            idle("R10", 0);
        end
        step("R9", 0, 0, '0, 0, '0, 1, 32'hF7FF_FFFF);
        step("R9", 0, 0, '0, 0, '0, 0, 32'h0800_0000);
        check("R9", flag_o, 1, "flag kept");
        ctrl_i[26] = 1'b0;
        idle("R10", 0);
        ctrl_i[26] = 1'b1;
        idle("R10", 0);
        step("R9", 0, 0, '0, 0, '0, 1, 32'h0800_0000);
        check("R10", irq_o, 0, "irq after clear");

        // R11: expiry and clear in the same cycle
        step("R11", 0, 1, 8'd1, 0, '0, 0, '0);
        step("R11", 1, 0, '0, 0, '0, 1, 32'hFFFF_FFFF);
        check("R11", flag_o, 1, "set wins");
        clear_flag("R9");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule